// File: doc/BRIEF.md
# Half-Duplex Command/Response Serial Master

This block is the master side of a three-wire-plus-select serial link in which every transfer is a single framed exchange. The master lowers an active-low select and keeps the serial clock running for the whole frame. It first shifts out a command of either 8 or 16 bits. One idle clock follows as a turnaround, and then a response of 4 to 16 bits is clocked in from the peripheral. The peripheral stays silent while the command goes out, so the link is half duplex. Frames therefore last from 13 to 33 serial clocks.

On the parallel side, a command word, a width-select bit and a response-length field are offered with a valid/ready handshake. One command may wait behind the frame in flight. When it does, it starts straight after that frame ends, with no gap in the select. Each finished frame raises a one-cycle done strobe with the response right-justified. The serial clock is derived from the system clock. Each half period lasts `HALF_DIV` system clocks.

Top module: `mw_master`

## Requirements
- R1: The command is sent most significant bit first. Its length is 16 bits when `cmd_long_i` is 1 and 8 bits when it is 0; an 8-bit command uses `cmd_i[7:0]` and ignores `cmd_i[15:8]`.
- R2: `tx_o` changes only on a falling edge of `sclk_o` or when a frame starts. The peripheral samples `tx_o` on rising edges.
- R3: The response length is `rsp_len_i` limited to the range 4..16 (values below 4 give 4, above 16 give 16). A frame has command length + 1 + response length rising edges of `sclk_o`.
- R4: Response bits are sampled from `rx_i` on rising edges, MSB first, beginning at the second rising edge after the last command bit. `rx_i` is ignored during the command and turnaround clocks.
- R5: `tx_o` is 0 during the turnaround and response clocks and while no frame is active.
- R6: `cs_n_o` is 0 throughout a frame. When no command is waiting, it returns to 1 at the falling edge of the frame's final clock, which is half a serial clock after the last response sample.
- R7: A command that is waiting when a frame ends starts on that same falling edge, with `cs_n_o` held low across the boundary.
- R8: At most one command can wait. `cmd_ready_o` is 0 while one waits, and `cmd_valid_i` has no effect while `cmd_ready_o` is 0.
- R9: One system clock after each frame's final falling edge, `done_o` is 1 for exactly one cycle. At the same time `rsp_o` holds the response right-justified, with zeros above it.
- R10: After reset, `cs_n_o` is 1, `sclk_o`, `tx_o` and `done_o` are 0, `rsp_o` is 0 and `cmd_ready_o` is 1.
- R11: `sclk_o` idles low. Every half period of `sclk_o`, and the delay from the fall of `cs_n_o` to the first rising edge, is `HALF_DIV` system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command slot free |
| cmd_i | input | 16 | Command word |
| cmd_long_i | input | 1 | 1: 16-bit command, 0: 8-bit command |
| rsp_len_i | input | 5 | Response length in bits |
| rx_i | input | 1 | Serial data from peripheral |
| cs_n_o | output | 1 | Active-low select |
| sclk_o | output | 1 | Serial clock |
| tx_o | output | 1 | Serial data to peripheral |
| done_o | output | 1 | Frame-complete strobe |
| rsp_o | output | 16 | Right-justified response |

## Verification
A bench-side peripheral model decodes each command from the wire and returns a queued response. The frames tried are the shortest (8+1+4) and the longest (16+1+16), mid-length short and long commands, and length codes outside the legal range. Together they separate width selection, clamping and off-by-one errors in the turnaround position. The model drives 1 on `rx_i` outside the response window, so a master that samples during the command or turnaround returns a different word. A burst of three queued commands tells a contiguous select apart from one that breaks between frames. A valid pulse raised while the slot is full shows whether a command leaks in.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int unsigned CMD_MAX_W = 16;
  localparam int unsigned CMD_MIN_W = 8;
  localparam int unsigned RSP_MAX_W = 16;
  localparam int unsigned RSP_MIN_W = 4;
  localparam int unsigned LEN_W     = $clog2(RSP_MAX_W + 1);
  localparam int unsigned IDX_W     = $clog2(CMD_MAX_W + 1 + RSP_MAX_W + 1);

  typedef struct packed {
    logic [CMD_MAX_W-1:0] cmd;
    logic                 long_cmd;
    logic [LEN_W-1:0]     rsp_len;
  } mw_req_t;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] len);
    if (len < LEN_W'(RSP_MIN_W)) return LEN_W'(RSP_MIN_W);
    if (len > LEN_W'(RSP_MAX_W)) return LEN_W'(RSP_MAX_W);
    return len;
  endfunction
endpackage

// File: rtl/mw_clk_gen.sv
module mw_clk_gen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (cnt_q == CNT_TOP) cnt_q <= '0;
    else                      cnt_q <= cnt_q + CNT_W'(1);
  end

  assign tick_o = run_i && (cnt_q == CNT_TOP);
endmodule

// File: rtl/mw_tx_shift.sv
module mw_tx_shift
  import mw_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [CMD_MAX_W-1:0] cmd_i,
  input  logic                 long_i,
  input  logic                 shift_i,
  output logic                 tx_o
);
  localparam int unsigned PAD_W = CMD_MAX_W - CMD_MIN_W;

  logic [CMD_MAX_W-1:0] sr_q;

  // left-align; zeros shifted in drive the line low after the command
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else if (load_i) sr_q <= long_i ? cmd_i : {cmd_i[CMD_MIN_W-1:0], {PAD_W{1'b0}}};
    else if (shift_i) sr_q <= {sr_q[CMD_MAX_W-2:0], 1'b0};
  end

  assign tx_o = sr_q[CMD_MAX_W-1];
endmodule

// File: rtl/mw_rx_shift.sv
module mw_rx_shift
  import mw_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 sample_i,
  input  logic                 rx_i,
  output logic [RSP_MAX_W-1:0] data_o
);
  logic [RSP_MAX_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (clr_i)    sr_q <= '0;
    else if (sample_i) sr_q <= {sr_q[RSP_MAX_W-2:0], rx_i};
  end

  assign data_o = sr_q;
endmodule

// File: rtl/mw_frame_ctl.sv
module mw_frame_ctl
  import mw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pend_vld_i,
  input  logic             pend_long_i,
  input  logic [LEN_W-1:0] pend_len_i,
  output logic             take_o,
  output logic             active_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             shift_o,
  output logic             sample_o,
  output logic             end_o
);
  logic             active_q, cs_n_q, sclk_q;
  logic [IDX_W-1:0] idx_q, cmd_len_q, tot_q;
  logic [IDX_W-1:0] cmd_len_d;
  logic             rise, fall, last;

  assign rise      = tick_i && !sclk_q;
  assign fall      = tick_i && sclk_q;
  assign last      = (idx_q == tot_q - IDX_W'(1));
  assign end_o     = fall && last;
  assign take_o    = pend_vld_i && (!active_q || end_o);
  assign shift_o   = fall && !last;
  // clock index > command length: past command and turnaround
  assign sample_o  = rise && (idx_q > cmd_len_q);
  assign cmd_len_d = pend_long_i ? IDX_W'(CMD_MAX_W) : IDX_W'(CMD_MIN_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      cs_n_q    <= 1'b1;
      sclk_q    <= 1'b0;
      idx_q     <= '0;
      cmd_len_q <= IDX_W'(CMD_MIN_W);
      tot_q     <= IDX_W'(CMD_MIN_W + 1 + RSP_MIN_W);
    end else if (take_o) begin
      active_q  <= 1'b1;
      cs_n_q    <= 1'b0;
      sclk_q    <= 1'b0;
      idx_q     <= '0;
      cmd_len_q <= cmd_len_d;
      tot_q     <= cmd_len_d + IDX_W'(1) + IDX_W'(pend_len_i);
    end else if (end_o) begin
      active_q  <= 1'b0;
      cs_n_q    <= 1'b1;
      sclk_q    <= 1'b0;
    end else if (rise) begin
      sclk_q    <= 1'b1;
    end else if (fall) begin
      sclk_q    <= 1'b0;
      idx_q     <= idx_q + IDX_W'(1);
    end
  end

  assign active_o = active_q;
  assign cs_n_o   = cs_n_q;
  assign sclk_o   = sclk_q;
endmodule

// File: rtl/mw_master.sv
module mw_master
  import mw_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  output logic                 cmd_ready_o,
  input  logic [CMD_MAX_W-1:0] cmd_i,
  input  logic                 cmd_long_i,
  input  logic [LEN_W-1:0]     rsp_len_i,
  input  logic                 rx_i,
  output logic                 cs_n_o,
  output logic                 sclk_o,
  output logic                 tx_o,
  output logic                 done_o,
  output logic [RSP_MAX_W-1:0] rsp_o
);
  mw_req_t              pend_q;
  logic                 pend_vld_q;
  logic                 take, active, tick, shift, sample, frame_end;
  logic [RSP_MAX_W-1:0] rx_data, rsp_q;
  logic                 done_q;

  assign cmd_ready_o = !pend_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q <= 1'b0;
      pend_q     <= '0;
    end else if (cmd_valid_i && !pend_vld_q) begin
      pend_vld_q       <= 1'b1;
      pend_q.cmd       <= cmd_i;
      pend_q.long_cmd  <= cmd_long_i;
      pend_q.rsp_len   <= clamp_len(rsp_len_i);
    end else if (take) begin
      pend_vld_q <= 1'b0;
    end
  end

  mw_clk_gen #(.HALF_DIV(HALF_DIV)) i_clk_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active),
    .tick_o (tick)
  );

  mw_frame_ctl i_frame_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .pend_vld_i  (pend_vld_q),
    .pend_long_i (pend_q.long_cmd),
    .pend_len_i  (pend_q.rsp_len),
    .take_o      (take),
    .active_o    (active),
    .cs_n_o      (cs_n_o),
    .sclk_o      (sclk_o),
    .shift_o     (shift),
    .sample_o    (sample),
    .end_o       (frame_end)
  );

  mw_tx_shift i_tx_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (take),
    .cmd_i   (pend_q.cmd),
    .long_i  (pend_q.long_cmd),
    .shift_i (shift),
    .tx_o    (tx_o)
  );

  mw_rx_shift i_rx_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (take),
    .sample_i (sample),
    .rx_i     (rx_i),
    .data_o   (rx_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      rsp_q  <= '0;
    end else begin
      done_q <= frame_end;
      if (frame_end) rsp_q <= rx_data;
    end
  end

  assign done_o = done_q;
  assign rsp_o  = rsp_q;
endmodule

// File: rtl/mw_master_chk.sv
module mw_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_valid_i,
  input logic cmd_ready_o,
  input logic cs_n_o,
  input logic sclk_o,
  input logic tx_o,
  input logic done_o
);
  // R2
  tx_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_o) |-> ($fell(sclk_o) || $fell(cs_n_o)));

  // R5
  tx_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !tx_o);

  // R6
  cs_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |-> $fell(sclk_o));

  // R11
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sclk_o);

  // R8
  slot_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind mw_master mw_master_chk i_mw_master_chk (.*);

// File: tb/test_mw_master.sv
`timescale 1ns/1ps
module test_mw_master;
  localparam int HALF = 2;
  localparam int TCK  = 20;

  typedef struct {
    logic [15:0] cmd;
    bit          lng;
    int          m;
    logic [15:0] rsp;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic [15:0] cmd_i = '0;
  logic        cmd_long_i = 1'b0;
  logic [4:0]  rsp_len_i = '0;
  logic        rx_i = 1'b1;
  logic        cs_n_o, sclk_o, tx_o, done_o;
  logic [15:0] rsp_o;

  int n_chk = 0, n_fail = 0;
  int dones = 0, cs_rises = 0;
  bit finished = 0;
  item_t exp_q[$];
  item_t ser_q[$];

  always #(TCK/2) clk_i = ~clk_i;

  mw_master #(.HALF_DIV(HALF)) i_mw_master (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // driver: offer a command and record what the peripheral must see
  task automatic send(input logic [15:0] c, input bit lng, input int len, input logic [15:0] r);
    item_t it;
    it.cmd = c; it.lng = lng;
    it.m   = (len < 4) ? 4 : (len > 16) ? 16 : len;
    it.rsp = r;
    do @(negedge clk_i); while (!cmd_ready_o);
    cmd_valid_i = 1'b1; cmd_i = c; cmd_long_i = lng; rsp_len_i = 5'(len);
    exp_q.push_back(it);
    ser_q.push_back(it);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || ser_q.size() != 0) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
  endtask

  // peripheral model
  int rc = 0, fc = 0, win_rises = 0, win_exp = 0;
  bit win_open = 0;
  logic [15:0] got = '0;
  time t_cs = 0, t_rise = 0;

  always @(negedge cs_n_o) begin
    win_open = 1; win_rises = 0; win_exp = 0; t_cs = $time;
  end

  always @(posedge cs_n_o) begin
    if (win_open) begin
      #1;
      chk(win_rises == win_exp, "R3", "clocks in select window", win_rises, win_exp);
      win_open = 0;
      cs_rises++;
    end
  end

  always @(posedge sclk_o) begin
    if (win_rises == 0)
      chk(($time - t_cs) == HALF*TCK, "R11", "select to first rise ns", $time - t_cs, HALF*TCK);
    t_rise = $time;
    win_rises++;
    chk(cs_n_o == 1'b0, "R6", "select during clock", cs_n_o, 0);
    if (ser_q.size() == 0) chk(0, "R8", "clock without a frame", 1, 0);
    else begin
      rc++;
      if (rc <= (ser_q[0].lng ? 16 : 8)) got = {got[14:0], tx_o};
      else chk(tx_o == 1'b0, "R5", "tx after command", tx_o, 0);
    end
  end

  always @(negedge sclk_o) begin
    int n, m;
    chk(($time - t_rise) == HALF*TCK, "R11", "high phase ns", $time - t_rise, HALF*TCK);
    if (ser_q.size() != 0) begin
      fc++;
      n = ser_q[0].lng ? 16 : 8;
      m = ser_q[0].m;
      // R4: noise outside the response window
      if (fc >= n + 1 && fc < n + 1 + m) rx_i = ser_q[0].rsp[m - 1 - (fc - n - 1)];
      else rx_i = 1'b1;
      if (fc == n + 1 + m) begin
        chk(got == (ser_q[0].lng ? ser_q[0].cmd : {8'h00, ser_q[0].cmd[7:0]}),
            "R1", "command bits", got, ser_q[0].lng ? ser_q[0].cmd : {8'h00, ser_q[0].cmd[7:0]});
        win_exp += n + 1 + m;
        void'(ser_q.pop_front());
        rc = 0; fc = 0; got = '0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      item_t it;
      logic [15:0] e;
      dones++;
      if (exp_q.size() == 0) chk(0, "R8", "unexpected done", rsp_o, 0);
      else begin
        it = exp_q.pop_front();
        e = it.rsp & 16'((32'h1 << it.m) - 1);
        chk(rsp_o == e, "R9", "response word", rsp_o, e);
      end
    end
  end

  initial begin
    #(200000 * TCK);
    chk(0, "watchdog", "timeout", 0, 1);
    finish_run();
  end

  initial begin
    int r0, d0;
    repeat (3) @(negedge clk_i);
    // R10
    chk(cs_n_o == 1'b1, "R10", "cs_n after reset", cs_n_o, 1);
    chk(sclk_o == 1'b0, "R10", "sclk after reset", sclk_o, 0);
    chk(tx_o == 1'b0, "R10", "tx after reset", tx_o, 0);
    chk(done_o == 1'b0, "R10", "done after reset", done_o, 0);
    chk(rsp_o == 16'h0, "R10", "rsp after reset", rsp_o, 0);
    chk(cmd_ready_o == 1'b1, "R10", "ready after reset", cmd_ready_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    send(16'hFFA5, 0, 8, 16'h003C);   // R1 upper byte ignored
    wait_idle();
    chk(cs_n_o == 1'b1, "R6", "select released", cs_n_o, 1);
    chk(tx_o == 1'b0, "R5", "tx idle", tx_o, 0);
    send(16'hC35A, 1, 16, 16'hBEEF);
    wait_idle();
    send(16'h0071, 0, 4, 16'h0005);   // R3 13 clocks
    wait_idle();
    send(16'h9D26, 1, 16, 16'h8001);  // R3 33 clocks
    wait_idle();
    send(16'h00F0, 0, 1, 16'hFFFA);   // R3 clamp up to 4
    wait_idle();
    send(16'h0F0F, 1, 31, 16'h1234);  // R3 clamp down to 16
    wait_idle();

    // R7 three contiguous frames, one select release
    r0 = cs_rises;
    send(16'h0033, 0, 12, 16'h0ABC);
    send(16'h7E81, 1, 5, 16'h0015);
    send(16'h00C6, 0, 16, 16'h6D3B);
    wait_idle();
    chk(cs_rises - r0 == 1, "R7", "select releases in burst", cs_rises - r0, 1);

    // R8 valid ignored while slot full
    d0 = dones;
    send(16'h1111, 1, 8, 16'h00AA);
    send(16'h0022, 0, 8, 16'h0055);
    chk(cmd_ready_o == 1'b0, "R8", "ready with waiting command", cmd_ready_o, 0);
    cmd_valid_i = 1'b1; cmd_i = 16'h0099; cmd_long_i = 1'b0; rsp_len_i = 5'd6;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    chk(cmd_ready_o == 1'b0, "R8", "ready after ignored valid", cmd_ready_o, 0);
    wait_idle();
    repeat (200) @(negedge clk_i);
    chk(dones - d0 == 2, "R8", "frames after ignored valid", dones - d0, 2);
    chk(exp_q.size() == 0, "R9", "results outstanding", exp_q.size(), 0);
    finish_run();
  end
endmodule